// File: doc/BRIEF.md
# Direction-Aware DMA Bus Arbiter

This block shares one data bus among a set of DMA channels, by default sixteen. Each channel asserts a request and a direction bit that says whether its next transfer reads or writes memory. The arbiter prefers requests that travel in the current preferred direction, so transfers going the same way are grouped together and the bus changes direction less often. Inside each group, fixed priority applies: the lower channel index wins.

A programmable period sets how long one direction stays preferred. A period counter is loaded from the period input. Each grant in the preferred direction uses up one count. When the count runs out, the preferred direction flips. The preference also moves when no request in the preferred direction is present and a request in the other direction is granted; the preferred direction then follows that grant. A period of zero turns the direction preference off and leaves plain fixed priority.

Top module: `dma_dir_arbiter`

## Requirements
- R1: With a nonzero period, among the requests whose direction bit equals `pref_dir`, the one with the lowest channel index is granted.
- R2: With a nonzero period, any request in the preferred direction beats every request in the opposite direction, whatever their indices. Example: channel 5 in the preferred direction beats channel 3 against it.
- R3: When every active request is against the preferred direction, the lowest-index request is still granted and `gnt_vld` is high. Example: against-traffic channels 3 and 6 give a grant to channel 3.
- R4: The counter is loaded from `period` at the first preferred-direction grant after reset and whenever `pref_dir` changes. After `period` consecutive grants in the preferred direction, counted from the last load, `pref_dir` inverts. The new value is visible in the same cycle as the last of those grants.
- R5: A grant whose direction differs from `pref_dir` sets `pref_dir` to that grant's direction and reloads the counter.
- R6: In a cycle with no request, `gnt` is all zero and `gnt_vld` is low in the following cycle. `pref_dir` and the counter keep their values.
- R7: When `period` is zero, the lowest-index request is granted regardless of direction. `pref_dir` still follows the direction of each grant.
- R8: Direction bit 0 means memory read and 1 means memory write. After reset `pref_dir` is 0 (read), `gnt` is zero and `gnt_vld` is low.
- R9: Outputs are registered. Requests sampled at one rising edge give `gnt` (bit i for channel i, at most one bit set) and `gnt_vld` after that edge, with `gnt_vld` high exactly when a bit of `gnt` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_CH | Per-channel transfer request |
| dir | input | NUM_CH | Per-channel direction, 0 read, 1 write |
| period | input | CNT_W | Preferred-direction grant budget, 0 disables the preference |
| gnt | output | NUM_CH | One-hot registered grant |
| gnt_vld | output | 1 | A grant is present this cycle |
| pref_dir | output | 1 | Current preferred direction |

## Verification
The assertions assume that `dir` bits are meaningful only where `req` is set. They also assume that `period` is a stable, known value during the cycles in which it is sampled, because the expiry and follow rules read it at every granted edge. The bench drives every input at the falling edge, so each rising edge sees settled values. It changes `period` only between directed phases, and in the random phase only at phase boundaries. Random masks keep `dir` fully defined, including on idle channels, and the bench mixes sparse, dense and empty request patterns so that all the grant and follow paths are reached.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
   typedef enum logic {
      XFER_RD = 1'b0,
      XFER_WR = 1'b1
   } xfer_dir_e;

   function automatic logic dir_opposite(input logic d);
      return ~d;
   endfunction
endpackage

// File: rtl/dmaarb_lowpick.sv
module dmaarb_lowpick #(
   parameter int N = 16
) (
   input  logic [N-1:0] cand,
   output logic [N-1:0] pick,
   output logic         found
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign pick[i]   = cand[i] & ~seen[i];
      assign seen[i+1] = seen[i] | cand[i];
   end

   assign found = seen[N];

   initial begin
      assert (N >= 1) else $error("lowpick: N must be at least 1");
   end
endmodule

// File: rtl/dmaarb_dirmask.sv
module dmaarb_dirmask #(
   parameter int N = 16
) (
   input  logic [N-1:0] req,
   input  logic [N-1:0] dir,
   input  logic         pref,
   input  logic         bias_en,
   output logic [N-1:0] cand
);
   logic [N-1:0] with_flow;
   logic         any_with;

   for (genvar i = 0; i < N; i++) begin : g_mask
      assign with_flow[i] = req[i] & (dir[i] == pref);
   end

   assign any_with = |with_flow;
   // A penalty at least as large as the channel count makes every
   // against-flow request lose to any with-flow request, so the
   // candidate set simply narrows to the with-flow group if non-empty.
   assign cand = (bias_en && any_with) ? with_flow : req;
endmodule

// File: rtl/dmaarb_flowctr.sv
module dmaarb_flowctr
   import dmaarb_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             win_dir,
   input  logic [CNT_W-1:0] period,
   output logic             pref
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] budget;
   logic             bias_en;

   assign bias_en = (period != '0);
   assign budget  = (cnt_q == '0) ? period : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pref  <= XFER_RD;
         cnt_q <= '0;
      end else if (fire) begin
         if (win_dir != pref) begin
            pref  <= win_dir;
            cnt_q <= period;
         end else if (bias_en) begin
            if (budget == CNT_W'(1)) begin
               pref  <= dir_opposite(pref);
               cnt_q <= period;
            end else begin
               cnt_q <= budget - CNT_W'(1);
            end
         end
      end
   end

   a_r6_idle_keeps_pref: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(pref));
   a_r6_idle_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(cnt_q));
   a_r5_follow_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && win_dir != pref) |=> (pref == $past(win_dir)));
   a_r7_disabled_no_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !bias_en && win_dir == pref) |=> $stable(pref));
endmodule

// File: rtl/dma_dir_arbiter.sv
module dma_dir_arbiter
   import dmaarb_pkg::*;
#(
   parameter int NUM_CH = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic [NUM_CH-1:0] dir,
   input  logic [CNT_W-1:0]  period,
   output logic [NUM_CH-1:0] gnt,
   output logic              gnt_vld,
   output logic              pref_dir
);
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   logic [NUM_CH-1:0] cand;
   logic [NUM_CH-1:0] win_oh;
   logic              win_any;
   logic              win_dir;
   logic              bias_en;

   initial begin
      assert (NUM_CH >= 2 && NUM_CH <= 64)
         else $error("dma_dir_arbiter: NUM_CH out of range");
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("dma_dir_arbiter: CNT_W out of range");
      assert (IDX_W >= 1) else $error("dma_dir_arbiter: bad IDX_W");
   end

   assign bias_en = (period != '0);

   dmaarb_dirmask #(.N(NUM_CH)) u_mask (
      .req     (req),
      .dir     (dir),
      .pref    (pref_dir),
      .bias_en (bias_en),
      .cand    (cand)
   );

   dmaarb_lowpick #(.N(NUM_CH)) u_pick (
      .cand  (cand),
      .pick  (win_oh),
      .found (win_any)
   );

   assign win_dir = |(win_oh & dir);

   dmaarb_flowctr #(.CNT_W(CNT_W)) u_flow (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (win_any),
      .win_dir (win_dir),
      .period  (period),
      .pref    (pref_dir)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gnt     <= '0;
         gnt_vld <= 1'b0;
      end else begin
         gnt     <= win_oh;
         gnt_vld <= win_any;
      end
   end

   a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt) && (gnt_vld == (gnt != '0)));
   a_r9_granted_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |=> (gnt_vld && ((gnt & $past(req)) == gnt)));
   a_r6_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |=> (!gnt_vld && gnt == '0));
   a_r2_with_flow_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bias_en && ((req & ~(dir ^ {NUM_CH{pref_dir}})) != '0))
      |=> ((gnt & ~($past(dir) ^ {NUM_CH{$past(pref_dir)}})) != '0));
   a_r7_plain_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (!bias_en && req != '0) |=> (gnt == ($past(req) & (~$past(req) + 1'b1))));
endmodule

// File: tb/dma_dir_arbiter_tb_top.sv
module dma_dir_arbiter_tb_top;
   localparam int N  = 16;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic [N-1:0]  dir = '0;
   logic [CW-1:0] period = '0;
   logic [N-1:0]  gnt;
   logic          gnt_vld;
   logic          pref_dir;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic          m_pref;
   logic [CW-1:0] m_cnt;

   always #2 clk = ~clk;

   dma_dir_arbiter #(.NUM_CH(N), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .dir(dir), .period(period),
      .gnt(gnt), .gnt_vld(gnt_vld), .pref_dir(pref_dir)
   );

   function automatic int pick_idx(input logic [N-1:0] r, input logic [N-1:0] d,
                                   input logic p, input logic [CW-1:0] per);
      int best = -1;
      int best_eff = 1000;
      for (int i = 0; i < N; i++) begin
         if (r[i]) begin
            int eff = i + ((per != 0 && d[i] != p) ? 16 : 0);
            if (eff < best_eff) begin
               best_eff = eff;
               best = i;
            end
         end
      end
      return best;
   endfunction

   task automatic check(input string rq, input string what, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic step(input logic [N-1:0] r, input logic [N-1:0] d, input string rq);
      int w;
      logic [N-1:0] e_gnt;
      logic wd;
      logic [CW-1:0] bud;
      req = r;
      dir = d;
      w = pick_idx(r, d, m_pref, period);
      e_gnt = (w < 0) ? '0 : (N'(1) << w);
      if (w >= 0) begin
         wd = d[w];
         bud = (m_cnt == 0) ? period : m_cnt;
         if (wd != m_pref) begin
            m_pref = wd;
            m_cnt = period;
         end else if (period != 0) begin
            if (bud == 1) begin
               m_pref = ~m_pref;
               m_cnt = period;
            end else m_cnt = bud - 1;
         end
      end
      @(posedge clk);
      #1;
      check(rq, "gnt", 32'(gnt), 32'(e_gnt));
      check(rq, "gnt_vld", 32'(gnt_vld), 32'(w >= 0));
      check(rq, "pref_dir", 32'(pref_dir), 32'(m_pref));
      @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      m_pref = 1'b0;
      m_cnt  = '0;
      period = 8'd4;
      repeat (3) @(negedge clk);
      // R8: reset state
      check("R8", "gnt", 32'(gnt), 0);
      check("R8", "gnt_vld", 32'(gnt_vld), 0);
      check("R8", "pref_dir", 32'(pref_dir), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R2: channel 5 reading (with flow) beats channel 3 writing (against)
      step(16'h0028, 16'h0008, "R2");
      // R1: several with-flow requests, lowest index wins
      step(16'h0f0c, 16'h0f00, "R1");
      // R6: idle cycle, no grant, preference held
      step(16'h0000, 16'h0000, "R6");
      // R3: channels 3 and 6 both against flow, channel 3 wins
      step(16'h0048, 16'h0048, "R3");
      // R5: pref now write; only a read request follows
      step(16'h0010, 16'h0000, "R5");
      // R4: period 3, count grants in read direction until flip
      period = 8'd3;
      step(16'h0004, 16'h0000, "R4");
      step(16'h0004, 16'h0000, "R4");
      step(16'h0004, 16'h0000, "R4");
      step(16'h0084, 16'h0080, "R4");
      // R7: period zero gives plain fixed priority
      period = 8'd0;
      step(16'h0028, 16'h0008, "R7");
      step(16'h0060, 16'h0040, "R7");
      step(16'h0000, 16'h0000, "R6");
      // R9: random mix, phases with fixed period
      for (int ph = 0; ph < 8; ph++) begin
         logic [CW-1:0] plist [5] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5};
         period = plist[$urandom % 5];
         for (int k = 0; k < 300; k++) begin
            logic [N-1:0] r;
            case ($urandom % 4)
               0: r = '0;
               1: r = N'($urandom) & N'($urandom) & N'($urandom);
               2: r = N'($urandom) & N'($urandom);
               default: r = N'($urandom);
            endcase
            step(r, N'($urandom), "R9");
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule